// File: doc/BRIEF.md
# Victim-Fill Second-Level Cache Bank Tag Controller

This block holds the tags and replacement state for one bank of a shared second-level cache that is filled only from lines thrown out of private first-level caches. A first-level miss is sent here as a lookup. The answer says whether the bank holds the line, whether some other first-level cache holds it, or neither. When both miss, the line comes straight from memory to the requester and the bank allocates nothing.

Evicted first-level lines arrive as victim operations. Each one is written into an 8-way set. Free ways are taken first, and after that a per-set rotating pointer chooses the way. When a dirty line is pushed out of the bank, a writeback address goes to memory.

The bank does not keep the first-level caches included. Instead it keeps a shadow of every first-level cache's tags, each with a 2-bit coherence state and an owner flag. A victim operation clears the shadow entry of the cache that sent it.

Top module: `vcb_bank_ctrl`

## Requirements
- R1: After reset, rsp_valid and wb_valid are 0, every bank way is invalid, every shadow entry has state 0, and every set pointer is 0.
- R2: An operation applied in one cycle is answered in the next cycle with rsp_valid=1. The operation codes are 0 lookup, 1 shadow write and 2 victim. For a lookup whose tag matches a valid way of set op_addr[3:0], the answer is rsp_bank_hit=1 with that way on rsp_way. The bank tag is op_addr[15:4].
- R3: A lookup never changes bank contents and never writes back. A line that missed still misses on the next lookup.
- R4: A victim whose tag is not in its set is written into the lowest-numbered invalid way. rsp_way gives that way and rsp_bank_hit is 0.
- R5: When every way of the set is valid, a new victim takes the way named by that set's pointer. Each set's pointer counts new allocations modulo 8, including allocations into invalid ways, and is independent of other sets.
- R6: If the displaced line was dirty, wb_valid=1 and wb_addr={old tag, set} in the same answer. A clean displaced line gives wb_valid=0.
- R7: A victim whose tag is already present merges into that way. It gives rsp_bank_hit=1 and the existing way, ORs the dirty flag, writes nothing back and leaves the pointer unchanged.
- R8: A shadow write stores op_state (0 invalid, 1 shared, 2 exclusive, 3 modified) and op_owner for cache op_src at index op_addr[2:0], with tag op_addr[15:3]. A lookup reports rsp_peer_hit for the lowest-numbered other cache whose entry has a non-zero state and a matching tag, together with its id, state and owner. The requester's own entry is never reported.
- R9: A victim clears the sender's shadow entry at its index in the same cycle, but only if the stored tag matches.
- R10: With op_valid=0 or op_code=3, nothing changes and rsp_valid is 0 the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 0 lookup, 1 shadow write, 2 victim, 3 no-op |
| op_src | input | 2 | Requesting first-level cache id |
| op_addr | input | 16 | Line address |
| op_state | input | 2 | Shadow state for a shadow write |
| op_owner | input | 1 | Owner flag for a shadow write |
| op_dirty | input | 1 | Victim line is dirty |
| rsp_valid | output | 1 | Answer for the previous cycle's operation |
| rsp_bank_hit | output | 1 | Line present in the bank |
| rsp_way | output | 3 | Hit, merge or allocated way |
| rsp_peer_hit | output | 1 | Another first-level cache holds the line |
| rsp_peer_id | output | 2 | Id of that cache |
| rsp_peer_state | output | 2 | Its shadow state |
| rsp_peer_owner | output | 1 | Its owner flag |
| wb_valid | output | 1 | Dirty line displaced |
| wb_addr | output | 16 | Address of the displaced line |

## Verification
Lookups are tried on empty sets, on freshly allocated lines, and on addresses that share a shadow index but differ in tag. These cases separate a bank hit from a peer hit from a full miss, and show that a miss does not allocate. One set is driven through eight victims and then past capacity, mixing clean and dirty lines and inserting merges. This shows free-way-first order apart from the rotating pointer, dirty from clean displacement, and a merge apart from an allocation. Shadow entries written by several caches check lowest-id priority and requester exclusion. The same entries then check that a victim clears the sender's entry only when the tag matches.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_SHADOW = 2'd1,
        OP_VICTIM = 2'd2,
        OP_NONE   = 2'd3
    } vcb_op_e;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2,
        ST_MOD = 2'd3
    } vcb_l1_state_e;
endpackage

// File: rtl/vcb_victim_pick.sv
module vcb_victim_pick #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAY_W-1:0] ptr,
    output logic [WAY_W-1:0] way
);
    logic             free_found;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
        way = free_found ? free_way : ptr;
    end
endmodule

// File: rtl/vcb_tag_array.sv
module vcb_tag_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 8,
    parameter int TAG_W = 12,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             alloc_en,
    input  logic             alloc_dirty,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] alloc_way,
    output logic             evict_dirty,
    output logic [TAG_W-1:0] evict_tag
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [TAG_W-1:0] tag_d   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  valid_d [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WAYS-1:0]  dirty_d [SETS];
    logic [WAY_W-1:0] ptr_q   [SETS];
    logic [WAY_W-1:0] ptr_d   [SETS];

    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] pick_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    vcb_victim_pick #(.WAYS(WAYS)) u_pick (
        .valid_vec (valid_q[lk_set]),
        .ptr       (ptr_q[lk_set]),
        .way       (pick_way)
    );

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
        alloc_way   = hit ? hit_way : pick_way;
        evict_tag   = tag_q[lk_set][pick_way];
        evict_dirty = !hit && valid_q[lk_set][pick_way] && dirty_q[lk_set][pick_way];
    end

    always_comb begin
        tag_d   = tag_q;
        valid_d = valid_q;
        dirty_d = dirty_q;
        ptr_d   = ptr_q;
        if (alloc_en) begin
            if (hit) begin
                dirty_d[lk_set][hit_way] = dirty_q[lk_set][hit_way] | alloc_dirty;
            end else begin
                tag_d[lk_set][pick_way]   = lk_tag;
                valid_d[lk_set][pick_way] = 1'b1;
                dirty_d[lk_set][pick_way] = alloc_dirty;
                ptr_d[lk_set]             = ptr_q[lk_set] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                ptr_q[s]   <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else begin
            tag_q   <= tag_d;
            valid_q <= valid_d;
            dirty_q <= dirty_d;
            ptr_q   <= ptr_d;
        end
    end
endmodule

// File: rtl/vcb_shadow_tags.sv
module vcb_shadow_tags #(
    parameter int NUM_L1  = 4,
    parameter int L1_SETS = 8,
    parameter int TAG_W   = 13,
    localparam int SRC_W = $clog2(NUM_L1),
    localparam int IDX_W = $clog2(L1_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             wr_en,
    input  logic [1:0]       wr_state,
    input  logic             wr_owner,
    input  logic             clr_en,
    output logic             peer_hit,
    output logic [SRC_W-1:0] peer_id,
    output logic [1:0]       peer_state,
    output logic             peer_owner
);
    logic [TAG_W-1:0] etag_q [NUM_L1][L1_SETS];
    logic [TAG_W-1:0] etag_d [NUM_L1][L1_SETS];
    logic [1:0]       est_q  [NUM_L1][L1_SETS];
    logic [1:0]       est_d  [NUM_L1][L1_SETS];
    logic             eown_q [NUM_L1][L1_SETS];
    logic             eown_d [NUM_L1][L1_SETS];

    logic [NUM_L1-1:0] peer_match;

    for (genvar c = 0; c < NUM_L1; c++) begin : g_peer
        assign peer_match[c] = (SRC_W'(c) != src) && (est_q[c][idx] != 2'd0)
                               && (etag_q[c][idx] == tag);
    end

    always_comb begin
        peer_hit   = |peer_match;
        peer_id    = '0;
        for (int c = NUM_L1 - 1; c >= 0; c--) begin
            if (peer_match[c]) peer_id = SRC_W'(c);
        end
        peer_state = peer_hit ? est_q[peer_id][idx] : 2'd0;
        peer_owner = peer_hit && eown_q[peer_id][idx];
    end

    always_comb begin
        etag_d = etag_q;
        est_d  = est_q;
        eown_d = eown_q;
        if (wr_en) begin
            etag_d[src][idx] = tag;
            est_d[src][idx]  = wr_state;
            eown_d[src][idx] = wr_owner;
        end else if (clr_en && (etag_q[src][idx] == tag)) begin
            est_d[src][idx]  = 2'd0;
            eown_d[src][idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_L1; c++) begin
                for (int i = 0; i < L1_SETS; i++) begin
                    etag_q[c][i] <= '0;
                    est_q[c][i]  <= '0;
                    eown_q[c][i] <= 1'b0;
                end
            end
        end else begin
            etag_q <= etag_d;
            est_q  <= est_d;
            eown_q <= eown_d;
        end
    end
endmodule

// File: rtl/vcb_bank_ctrl.sv
module vcb_bank_ctrl #(
    parameter int ADDR_W  = 16,
    parameter int SETS    = 16,
    parameter int WAYS    = 8,
    parameter int NUM_L1  = 4,
    parameter int L1_SETS = 8,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int SRC_W  = $clog2(NUM_L1),
    localparam int IDX_W  = $clog2(L1_SETS),
    localparam int BTAG_W = ADDR_W - SET_W,
    localparam int STAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [SRC_W-1:0]  op_src,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [1:0]        op_state,
    input  logic              op_owner,
    input  logic              op_dirty,
    output logic              rsp_valid,
    output logic              rsp_bank_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_peer_hit,
    output logic [SRC_W-1:0]  rsp_peer_id,
    output logic [1:0]        rsp_peer_state,
    output logic              rsp_peer_owner,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr
);
    import vcb_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              bank_hit;
        logic [WAY_W-1:0]  way;
        logic              peer_hit;
        logic [SRC_W-1:0]  peer_id;
        logic [1:0]        peer_state;
        logic              peer_owner;
        logic              wb;
        logic [ADDR_W-1:0] wb_addr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic              is_lookup, is_shadow, is_victim;
    logic [SET_W-1:0]  bset;
    logic [BTAG_W-1:0] btag;
    logic              b_hit, b_evict_dirty;
    logic [WAY_W-1:0]  b_hit_way, b_alloc_way;
    logic [BTAG_W-1:0] b_evict_tag;
    logic              s_hit, s_owner;
    logic [SRC_W-1:0]  s_id;
    logic [1:0]        s_state;

    assign is_lookup = op_valid && (op_code == OP_LOOKUP);
    assign is_shadow = op_valid && (op_code == OP_SHADOW);
    assign is_victim = op_valid && (op_code == OP_VICTIM);
    assign bset      = op_addr[SET_W-1:0];
    assign btag      = op_addr[ADDR_W-1:SET_W];

    vcb_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(BTAG_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_set      (bset),
        .lk_tag      (btag),
        .alloc_en    (is_victim),
        .alloc_dirty (op_dirty),
        .hit         (b_hit),
        .hit_way     (b_hit_way),
        .alloc_way   (b_alloc_way),
        .evict_dirty (b_evict_dirty),
        .evict_tag   (b_evict_tag)
    );

    vcb_shadow_tags #(.NUM_L1(NUM_L1), .L1_SETS(L1_SETS), .TAG_W(STAG_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (op_src),
        .idx        (op_addr[IDX_W-1:0]),
        .tag        (op_addr[ADDR_W-1:IDX_W]),
        .wr_en      (is_shadow),
        .wr_state   (op_state),
        .wr_owner   (op_owner),
        .clr_en     (is_victim),
        .peer_hit   (s_hit),
        .peer_id    (s_id),
        .peer_state (s_state),
        .peer_owner (s_owner)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = is_lookup || is_shadow || is_victim;
        if (is_lookup) begin
            rsp_d.bank_hit   = b_hit;
            rsp_d.way        = b_hit ? b_hit_way : '0;
            rsp_d.peer_hit   = s_hit;
            rsp_d.peer_id    = s_id;
            rsp_d.peer_state = s_state;
            rsp_d.peer_owner = s_owner;
        end else if (is_victim) begin
            rsp_d.bank_hit = b_hit;
            rsp_d.way      = b_alloc_way;
            rsp_d.wb       = b_evict_dirty;
            rsp_d.wb_addr  = b_evict_dirty ? {b_evict_tag, bset} : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_bank_hit   = rsp_q.bank_hit;
    assign rsp_way        = rsp_q.way;
    assign rsp_peer_hit   = rsp_q.peer_hit;
    assign rsp_peer_id    = rsp_q.peer_id;
    assign rsp_peer_state = rsp_q.peer_state;
    assign rsp_peer_owner = rsp_q.peer_owner;
    assign wb_valid       = rsp_q.wb;
    assign wb_addr        = rsp_q.wb_addr;
endmodule

// File: rtl/vcb_bank_ctrl_chk.sv
module vcb_bank_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int WAY_W  = 3,
    parameter int SRC_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_code,
    input logic [SRC_W-1:0]  op_src,
    input logic              rsp_valid,
    input logic              rsp_bank_hit,
    input logic [WAY_W-1:0]  rsp_way,
    input logic              rsp_peer_hit,
    input logic [SRC_W-1:0]  rsp_peer_id,
    input logic [1:0]        rsp_peer_state,
    input logic              rsp_peer_owner,
    input logic              wb_valid,
    input logic [ADDR_W-1:0] wb_addr
);
    logic             prev_lookup_q, prev_victim_q;
    logic [SRC_W-1:0] prev_src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lookup_q <= 1'b0;
            prev_victim_q <= 1'b0;
            prev_src_q    <= '0;
        end else begin
            prev_lookup_q <= op_valid && (op_code == 2'd0);
            prev_victim_q <= op_valid && (op_code == 2'd2);
            prev_src_q    <= op_src;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !wb_valid));

    assert_answer_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code != 2'd3) |=> rsp_valid);

    assert_lookup_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_lookup_q |-> !wb_valid);

    assert_wb_from_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (rsp_valid && prev_victim_q));

    assert_merge_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_victim_q && rsp_bank_hit) |-> !wb_valid);

    assert_peer_valid_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_peer_hit |-> (prev_lookup_q && rsp_peer_state != 2'd0 && rsp_peer_id != prev_src_q));

    assert_peer_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_peer_hit |-> (rsp_peer_state == 2'd0 && !rsp_peer_owner));

    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_code != 2'd3) |=> (!rsp_valid && !rsp_bank_hit && !wb_valid));

    logic unused_ok;
    assign unused_ok = ^{rsp_way, wb_addr};
endmodule

bind vcb_bank_ctrl vcb_bank_ctrl_chk #(.ADDR_W(ADDR_W), .WAY_W(WAY_W), .SRC_W(SRC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .op_code        (op_code),
    .op_src         (op_src),
    .rsp_valid      (rsp_valid),
    .rsp_bank_hit   (rsp_bank_hit),
    .rsp_way        (rsp_way),
    .rsp_peer_hit   (rsp_peer_hit),
    .rsp_peer_id    (rsp_peer_id),
    .rsp_peer_state (rsp_peer_state),
    .rsp_peer_owner (rsp_peer_owner),
    .wb_valid       (wb_valid),
    .wb_addr        (wb_addr)
);

// File: tb/vcb_bank_ctrl_tb.sv
module vcb_bank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [1:0]  op_src = 2'd0;
    logic [15:0] op_addr = 16'd0;
    logic [1:0]  op_state = 2'd0;
    logic        op_owner = 1'b0;
    logic        op_dirty = 1'b0;
    logic        rsp_valid, rsp_bank_hit, rsp_peer_hit, rsp_peer_owner, wb_valid;
    logic [2:0]  rsp_way;
    logic [1:0]  rsp_peer_id, rsp_peer_state;
    logic [15:0] wb_addr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vcb_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_src(op_src), .op_addr(op_addr), .op_state(op_state),
        .op_owner(op_owner), .op_dirty(op_dirty), .rsp_valid(rsp_valid),
        .rsp_bank_hit(rsp_bank_hit), .rsp_way(rsp_way), .rsp_peer_hit(rsp_peer_hit),
        .rsp_peer_id(rsp_peer_id), .rsp_peer_state(rsp_peer_state),
        .rsp_peer_owner(rsp_peer_owner), .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    // packed answer: valid, bank_hit, way[3], peer_hit, peer_id[2], peer_state[2], owner, wb, wb_addr[16]
    typedef logic [27:0] ans_t;

    typedef struct packed {
        logic [1:0]  code;
        logic [1:0]  src;
        logic [15:0] addr;
        logic [1:0]  st;
        logic        own;
        logic        dirty;
        ans_t        exp;
        int          req;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 2'd0, 16'h0125, 2'd0, 1'b0, 1'b0, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 3},  // R3 miss
        '{2'd0, 2'd0, 16'h0125, 2'd0, 1'b0, 1'b0, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 3},  // R3 still miss
        '{2'd2, 2'd1, 16'h0125, 2'd0, 1'b0, 1'b1, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 4},  // R4 way 0
        '{2'd0, 2'd0, 16'h0125, 2'd0, 1'b0, 1'b0, {1'b1,1'b1,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 2},  // R2 hit
        '{2'd2, 2'd2, 16'h0235, 2'd0, 1'b0, 1'b0, {1'b1,1'b0,3'd1,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 4},  // R4 way 1
        '{2'd2, 2'd2, 16'h0125, 2'd0, 1'b0, 1'b0, {1'b1,1'b1,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 7},  // R7 merge
        '{2'd1, 2'd2, 16'h0340, 2'd3, 1'b1, 1'b0, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 8},  // R8 write
        '{2'd1, 2'd1, 16'h0340, 2'd1, 1'b0, 1'b0, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 8},  // R8 write
        '{2'd0, 2'd3, 16'h0340, 2'd0, 1'b0, 1'b0, {1'b1,1'b0,3'd0,1'b1,2'd1,2'd1,1'b0,1'b0,16'h0000}, 8},  // R8 lowest id
        '{2'd0, 2'd1, 16'h0340, 2'd0, 1'b0, 1'b0, {1'b1,1'b0,3'd0,1'b1,2'd2,2'd3,1'b1,1'b0,16'h0000}, 8},  // R8 own excluded
        '{2'd0, 2'd2, 16'h0348, 2'd0, 1'b0, 1'b0, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 8},  // R8 tag differs
        '{2'd2, 2'd1, 16'h0340, 2'd0, 1'b0, 1'b1, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 9},  // R9 victim clears
        '{2'd0, 2'd3, 16'h0340, 2'd0, 1'b0, 1'b0, {1'b1,1'b1,3'd0,1'b1,2'd2,2'd3,1'b1,1'b0,16'h0000}, 9},  // R9 cleared
        '{2'd1, 2'd0, 16'h0350, 2'd0, 1'b1, 1'b0, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 8},  // R8 invalid write
        '{2'd0, 2'd3, 16'h0350, 2'd0, 1'b0, 1'b0, {1'b1,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 8},  // R8 state 0 no hit
        '{2'd3, 2'd0, 16'h0125, 2'd0, 1'b0, 1'b1, {1'b0,1'b0,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 10}, // R10 no-op
        '{2'd0, 2'd0, 16'h0125, 2'd0, 1'b0, 1'b0, {1'b1,1'b1,3'd0,1'b0,2'd0,2'd0,1'b0,1'b0,16'h0000}, 10}  // R10 unchanged
    };

    function automatic ans_t actual();
        return {rsp_valid, rsp_bank_hit, rsp_way, rsp_peer_hit, rsp_peer_id,
                rsp_peer_state, rsp_peer_owner, wb_valid, wb_addr};
    endfunction

    function automatic ans_t vic(input logic bh, input logic [2:0] way,
                                 input logic wb, input logic [15:0] wa);
        return {1'b1, bh, way, 1'b0, 2'd0, 2'd0, 1'b0, wb, wa};
    endfunction

    task automatic run_op(input logic [1:0] code, input logic [1:0] src,
                          input logic [15:0] addr, input logic [1:0] st,
                          input logic own, input logic dirty);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_src = src; op_addr = addr;
        op_state = st; op_owner = own; op_dirty = dirty;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic check(input ans_t exp, input string req);
        ans_t act;
        act = actual();
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1: quiet outputs after reset
        check('0, "R1");
        for (int i = 0; i < NVEC; i++) begin
            run_op(TBL[i].code, TBL[i].src, TBL[i].addr, TBL[i].st, TBL[i].own, TBL[i].dirty);
            check(TBL[i].exp, $sformatf("R%0d vec %0d", TBL[i].req, i));
        end

        do_reset();
        check('0, "R1 outputs");
        run_op(2'd0, 2'd3, 16'h0125, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd0, 1'b0, 16'h0), "R1 bank empty");
        run_op(2'd0, 2'd0, 16'h0340, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd0, 1'b0, 16'h0), "R1 shadow empty");

        // R4: eight fresh tags into set 9 fill ways 0..7
        for (int t = 1; t <= 8; t++) begin
            run_op(2'd2, 2'd0, 16'(t * 16 + 9), 2'd0, 1'b0, (t % 2) == 0);
            check(vic(1'b0, 3'(t - 1), 1'b0, 16'h0), "R4 free way");
        end
        // R5: pointer wrapped to 0 after eight allocations; tag 1 clean
        run_op(2'd2, 2'd0, 16'h0099, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd0, 1'b0, 16'h0), "R5 pointer way 0");
        // R6: tag 2 was dirty
        run_op(2'd2, 2'd0, 16'h00A9, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd1, 1'b1, 16'h0029), "R6 dirty writeback");
        // R5: other set untouched
        run_op(2'd2, 2'd0, 16'h001A, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd0, 1'b0, 16'h0), "R5 independent set");
        // R6: tag 3 clean
        run_op(2'd2, 2'd0, 16'h00B9, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd2, 1'b0, 16'h0), "R6 clean displace");
        // R7: merge keeps pointer at 3
        run_op(2'd2, 2'd1, 16'h0049, 2'd0, 1'b0, 1'b0);
        check(vic(1'b1, 3'd3, 1'b0, 16'h0), "R7 merge");
        run_op(2'd2, 2'd0, 16'h00C9, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd3, 1'b1, 16'h0049), "R7 pointer unchanged");
        // R7: dirty merged into clean tag 5
        run_op(2'd2, 2'd1, 16'h0059, 2'd0, 1'b0, 1'b1);
        check(vic(1'b1, 3'd4, 1'b0, 16'h0), "R7 dirty merge");
        run_op(2'd2, 2'd0, 16'h00D9, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd4, 1'b1, 16'h0059), "R7 merged dirty written back");
        // R3 and R2 after displacement
        run_op(2'd0, 2'd0, 16'h0019, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd0, 1'b0, 16'h0), "R3 displaced line misses");
        run_op(2'd0, 2'd0, 16'h00D9, 2'd0, 1'b0, 1'b0);
        check(vic(1'b1, 3'd4, 1'b0, 16'h0), "R2 hit way 4");

        // R9: clear only on tag match
        run_op(2'd1, 2'd0, 16'h0123, 2'd2, 1'b0, 1'b0);
        check(vic(1'b0, 3'd0, 1'b0, 16'h0), "R8 shadow write");
        run_op(2'd2, 2'd0, 16'h0323, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd0, 1'b0, 16'h0), "R9 other tag victim");
        run_op(2'd0, 2'd1, 16'h0123, 2'd0, 1'b0, 1'b0);
        check({1'b1, 1'b0, 3'd0, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 16'h0}, "R9 entry kept");
        run_op(2'd2, 2'd0, 16'h0123, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd1, 1'b0, 16'h0), "R9 matching victim");
        run_op(2'd0, 2'd1, 16'h0123, 2'd0, 1'b0, 1'b0);
        check(vic(1'b1, 3'd1, 1'b0, 16'h0), "R9 entry cleared");

        // R10: op_valid low with a victim code does nothing
        @(negedge clk);
        op_valid = 1'b0; op_code = 2'd2; op_addr = 16'h0777; op_dirty = 1'b1;
        @(negedge clk);
        check('0, "R10 idle");
        run_op(2'd0, 2'd0, 16'h0777, 2'd0, 1'b0, 1'b0);
        check(vic(1'b0, 3'd0, 1'b0, 16'h0), "R10 nothing allocated");

        finish_run();
    end
endmodule